// File: doc/BRIEF.md
# Two-Stage Periodic Interrupt Timer

The block produces periodic time-out events on eight independent channels. Time is divided in two stages. Two shared 8-bit micro timers each divide the clock and emit a one-cycle tick at every zero crossing. Each channel has a 16-bit down-counter that picks one of the two micro timers as its time base and counts its ticks. When a channel's counter and its chosen micro timer reach zero together, the channel's time-out flag is set and the counter reloads. If the channel's interrupt enable is on, an interrupt request is raised.

All settings go through a plain single-cycle register bus. This covers the load values, the module and channel enables, the time-base selection, the interrupt enables and the immediate-reload strobes. Software reads the flags through the same bus and clears them by writing ones. A new load value normally takes effect only when its counter next reaches zero. A strobe makes it take effect at once.

Top module: `pit_timer`

## Requirements
- R1: After reset all load values, enables, selections and flags read as zero and every interrupt request is low.
- R2: Register map, one write per cycle, with read data on `bus_rdata` one edge after the address is sampled. 0 is the module enable (bit 0). 1 holds the channel enables (bit c). 2 holds the time-base selection (bit c, 1 picks micro timer 1). 3 holds the interrupt enables. 4 holds the reload strobes: bits 1:0 are micro timers and bits 15:8 are channels, and the address reads zero. 5 holds the flags (read, write-one-to-clear). 6 and 7 are the micro timer 0 and 1 loads. 8+c is the load for channel c. Every writable register except the strobes reads back its value.
- R3: With micro load L and channel load N, the first flag of a channel rises (N+1)(L+1) clock edges after the edge that writes the module enable, provided the channel was already enabled.
- R4: Further time-outs of a running channel follow every (N+1)(L+1) edges.
- R5: A channel counts only the ticks of the micro timer its selection bit names.
- R6: Writing a micro timer load does not restart its count. The new value is used from the next zero crossing on.
- R7: A micro timer reload strobe copies that timer's load value into its count at the strobe's edge.
- R8: A channel reload strobe copies the channel's load into its counter at the strobe's edge and leaves the flags unchanged.
- R9: Writing 1 to a flag bit clears it. Writing 0 has no effect.
- R10: If a time-out and a clearing write hit the same flag on the same edge, the flag ends set.
- R11: A disabled channel's flag is cleared. With the module disabled, all flags are cleared.
- R12: A channel's interrupt request is high exactly while its flag and its interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_addr | input | 4 | Register address (read and write) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the address of the previous edge |
| tout_flag | output | 8 | Per-channel time-out flags |
| irq | output | 8 | Per-channel interrupt requests |

## Verification
The assertions assume that a single bus write happens per cycle. As a result, a reload strobe and a flag-clearing write never reach the same channel on the same edge. The channel reload property relies on this when it claims that the flag is unchanged. The bench drives every access through a task that issues exactly one write and then drops the strobe. It also takes each measurement from a known start: the module is disabled first, then configured, then enabled last.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int NUM_MT = 2;
  // register addresses; channel loads occupy A_CHLD upward
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_CHEN = 4'd1;
  localparam logic [ADDR_W-1:0] A_SEL  = 4'd2;
  localparam logic [ADDR_W-1:0] A_IE   = 4'd3;
  localparam logic [ADDR_W-1:0] A_FRC  = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd5;
  localparam logic [ADDR_W-1:0] A_MT0  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MT1  = 4'd7;
  localparam int                A_CHLD = 8;
  localparam int                FRC_CH_LSB = 8;
endpackage

// File: rtl/pit_microtimer.sv
module pit_microtimer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         force_ld,
  input  logic [W-1:0] ld,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (!run || force_ld) cnt <= ld;
    else if (cnt == '0)        cnt <= ld;
    else                       cnt <= cnt - 1'b1;
  end

  assign tick = run && !force_ld && (cnt == '0);

  // R7
  mt_force_chk: assert property (@(posedge clk) disable iff (rst)
    run && force_ld |=> cnt == $past(ld));
  // R3
  mt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    run && !force_ld && cnt != '0 |=> cnt == W'($past(cnt) - 1));
  // R6
  mt_reload_chk: assert property (@(posedge clk) disable iff (rst)
    run && !force_ld && cnt == '0 |=> cnt == $past(ld));
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         force_ld,
  input  logic         clr,
  input  logic [W-1:0] ld,
  output logic         flag
);
  logic [W-1:0] cnt;
  logic         timeout;

  assign timeout = run && !force_ld && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (!run || force_ld) cnt <= ld;
    else if (tick)             cnt <= (cnt == '0) ? ld : cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) flag <= 1'b0;
    else if (timeout) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |=> flag);
  // R11
  ch_off_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !flag);
  // R8
  ch_force_chk: assert property (@(posedge clk) disable iff (rst)
    run && force_ld && !clr |=> cnt == $past(ld) && flag == $past(flag));
  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    run && clr && !timeout |=> !flag);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    run && !force_ld && !tick |=> $stable(cnt));
endmodule

// File: rtl/pit_regbank.sv
module pit_regbank
  import pit_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int MT_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM_CH-1:0]            flags,
  output logic                         mod_en,
  output logic [NUM_CH-1:0]            ch_en,
  output logic [NUM_CH-1:0]            sel,
  output logic [NUM_CH-1:0]            ie,
  output logic [NUM_MT-1:0][MT_W-1:0]  mt_ld,
  output logic [NUM_CH-1:0][CNT_W-1:0] ch_ld,
  output logic [NUM_MT-1:0]            frc_mt,
  output logic [NUM_CH-1:0]            frc_ch,
  output logic [NUM_CH-1:0]            clr,
  output logic [DATA_W-1:0]            rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mod_en <= 1'b0;
      ch_en  <= '0;
      sel    <= '0;
      ie     <= '0;
      mt_ld  <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: mod_en   <= wdata[0];
        A_CHEN: ch_en    <= wdata[NUM_CH-1:0];
        A_SEL:  sel      <= wdata[NUM_CH-1:0];
        A_IE:   ie       <= wdata[NUM_CH-1:0];
        A_MT0:  mt_ld[0] <= wdata[MT_W-1:0];
        A_MT1:  mt_ld[1] <= wdata[MT_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ld
    always_ff @(posedge clk) begin
      if (rst) ch_ld[g] <= '0;
      else if (we && addr == ADDR_W'(A_CHLD + g)) ch_ld[g] <= wdata[CNT_W-1:0];
    end
  end

  assign frc_mt = (we && addr == A_FRC)  ? wdata[NUM_MT-1:0]           : '0;
  assign frc_ch = (we && addr == A_FRC)  ? wdata[FRC_CH_LSB +: NUM_CH] : '0;
  assign clr    = (we && addr == A_FLAG) ? wdata[NUM_CH-1:0]           : '0;

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_CTRL: rdata <= DATA_W'(mod_en);
        A_CHEN: rdata <= DATA_W'(ch_en);
        A_SEL:  rdata <= DATA_W'(sel);
        A_IE:   rdata <= DATA_W'(ie);
        A_FLAG: rdata <= DATA_W'(flags);
        A_MT0:  rdata <= DATA_W'(mt_ld[0]);
        A_MT1:  rdata <= DATA_W'(mt_ld[1]);
        default: begin
          rdata <= '0;
          for (int i = 0; i < NUM_CH; i++)
            if (addr == ADDR_W'(A_CHLD + i)) rdata <= DATA_W'(ch_ld[i]);
        end
      endcase
    end
  end

  // R9
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |-> (frc_ch == '0));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int MT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [NUM_CH-1:0] tout_flag,
  output logic [NUM_CH-1:0] irq
);
  logic                         mod_en;
  logic [NUM_CH-1:0]            ch_en, sel, ie, frc_ch, clr;
  logic [NUM_MT-1:0]            frc_mt, mt_tick;
  logic [NUM_MT-1:0][MT_W-1:0]  mt_ld;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_ld;

  pit_regbank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .MT_W(MT_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .flags(tout_flag), .mod_en(mod_en), .ch_en(ch_en), .sel(sel), .ie(ie),
    .mt_ld(mt_ld), .ch_ld(ch_ld), .frc_mt(frc_mt), .frc_ch(frc_ch),
    .clr(clr), .rdata(bus_rdata)
  );

  for (genvar m = 0; m < NUM_MT; m++) begin : g_mt
    pit_microtimer #(.W(MT_W)) u_mt (
      .clk(clk), .rst(rst), .run(mod_en), .force_ld(frc_mt[m]),
      .ld(mt_ld[m]), .tick(mt_tick[m])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pit_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .run(mod_en && ch_en[c]), .tick(mt_tick[sel[c]]),
      .force_ld(frc_ch[c]), .clr(clr[c]), .ld(ch_ld[c]), .flag(tout_flag[c])
    );
  end

  assign irq = tout_flag & ie;

  // R11
  mod_off_chk: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> tout_flag == '0);
  // R1
  rst_chk: assert property (@(posedge clk)
    $past(rst) |-> tout_flag == '0 && bus_rdata == '0);
endmodule

// File: tb/test_pit_timer.sv
module test_pit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  tout_flag, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pit_timer i_pit_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tout_flag(tout_flag), .irq(irq)
  );

  // {channel, selection, micro load, channel load}
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{0, 0, 0, 0}, '{1, 1, 3, 4}, '{2, 0, 7, 1},
    '{7, 1, 0, 9}, '{5, 0, 2, 2}, '{3, 1, 15, 3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    v = bus_rdata;
  endtask

  task automatic wait_flag(input int ch, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!tout_flag[ch] && n < 5000);
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int ch, s, l, n, p, cnt;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    #1;
    chk(tout_flag == 0 && irq == 0, "R1 outputs", int'({tout_flag, irq}), 0);
    rd(4'd5, v);  chk(v == 0, "R1 flags reg", v, 0);
    rd(4'd7, v);  chk(v == 0, "R1 micro load", v, 0);
    rd(4'd15, v); chk(v == 0, "R1 channel load", v, 0);

    // R2 readback
    wr(4'd15, 16'hBEEF); rd(4'd15, v); chk(v == 16'hBEEF, "R2 ch7 load", v, 16'hBEEF);
    wr(4'd2, 16'h00A5);  rd(4'd2, v);  chk(v == 16'h00A5, "R2 select", v, 16'h00A5);
    wr(4'd6, 16'h0033);  rd(4'd6, v);  chk(v == 16'h0033, "R2 micro0 load", v, 16'h0033);
    rd(4'd4, v); chk(v == 0, "R2 strobe reads zero", v, 0);

    // R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      ch = VEC[i][0]; s = VEC[i][1]; l = VEC[i][2]; n = VEC[i][3];
      p = (n + 1) * (l + 1);
      wr(4'd0, 16'd0);
      wr(s ? 4'd7 : 4'd6, 16'(l));
      wr(s ? 4'd6 : 4'd7, 16'(l + 3));
      wr(4'(8 + ch), 16'(n));
      wr(4'd2, 16'(s << ch));
      wr(4'd1, 16'(1 << ch));
      wr(4'd0, 16'd1);
      wait_flag(ch, cnt);
      chk(cnt == p, "R3 R5 first period", cnt, p);
      if (p >= 2) begin
        wr(4'd5, 16'(1 << ch));
        wait_flag(ch, cnt);
        chk(cnt == p - 1, "R4 next period", cnt, p - 1);
      end
    end

    // R10 R9: L=1 N=2 on ch0, period 6
    wr(4'd0, 16'd0); wr(4'd6, 16'd1); wr(4'd8, 16'd2);
    wr(4'd2, 16'd0); wr(4'd1, 16'd1); wr(4'd0, 16'd1);
    wait_flag(0, cnt);
    chk(cnt == 6, "R3 period 6", cnt, 6);
    edges(5);
    wr(4'd5, 16'd1);
    chk(tout_flag[0] == 1'b1, "R10 set beats clear", tout_flag[0], 1);
    wr(4'd5, 16'd0);
    chk(tout_flag[0] == 1'b1, "R9 write zero", tout_flag[0], 1);
    wr(4'd5, 16'd1);
    chk(tout_flag[0] == 1'b0, "R9 write one clears", tout_flag[0], 0);

    // R6: L=9 N=0, load rewritten mid-count
    wr(4'd0, 16'd0); wr(4'd6, 16'd9); wr(4'd8, 16'd0); wr(4'd0, 16'd1);
    edges(2);
    wr(4'd6, 16'd3);
    wait_flag(0, cnt);
    chk(cnt == 7, "R6 no restart", cnt, 7);
    wr(4'd5, 16'd1);
    wait_flag(0, cnt);
    chk(cnt == 3, "R6 new load at zero", cnt, 3);

    // R7: micro timer strobe
    wr(4'd0, 16'd0); wr(4'd6, 16'd9); wr(4'd0, 16'd1);
    wr(4'd6, 16'd2);
    wr(4'd4, 16'h0001);
    wait_flag(0, cnt);
    chk(cnt == 3, "R7 micro strobe", cnt, 3);

    // R8: channel strobe, L=0 N=9
    wr(4'd0, 16'd0); wr(4'd6, 16'd0); wr(4'd8, 16'd9); wr(4'd0, 16'd1);
    wr(4'd8, 16'd2);
    wr(4'd4, 16'h0100);
    wait_flag(0, cnt);
    chk(cnt == 3, "R8 channel strobe", cnt, 3);
    wr(4'd4, 16'h0100);
    chk(tout_flag[0] == 1'b1, "R8 flag kept", tout_flag[0], 1);

    // R12 interrupt gating
    chk(irq[0] == 1'b0, "R12 disabled irq", irq[0], 0);
    wr(4'd3, 16'd1);
    chk(irq[0] == 1'b1, "R12 enabled irq", irq[0], 1);

    // R11: ch0 and ch1 both flagged, then disables
    wr(4'd0, 16'd0); wr(4'd8, 16'd0); wr(4'd9, 16'd0);
    wr(4'd1, 16'd3); wr(4'd0, 16'd1);
    edges(2);
    chk(tout_flag[1:0] == 2'b11, "R11 both set", tout_flag[1:0], 3);
    wr(4'd1, 16'd1);
    edges(1);
    chk(tout_flag[1:0] == 2'b01, "R11 channel off", tout_flag[1:0], 1);
    wr(4'd0, 16'd0);
    edges(1);
    chk(tout_flag == 0, "R11 module off", tout_flag, 0);
    chk(irq == 0, "R12 irq follows flag", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule